// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Modes

This peripheral controls sixteen general-purpose pins through a small synchronous register bus. The pins are grouped into four banks of unequal width: two, four, four and six pins. Each bank has a level register and a mode register. A single shared register chooses, pin by pin, between actively driven output and open-drain output. On the pad side, each pin has an output level, an output enable and an input level. Input levels cross into the clock domain through a two-flop synchronizer.

Software selects a pin's behaviour by writing a 4-bit mode code into the pin's nibble of its bank's mode register. Code 0x8 turns the output driver on. Every other code leaves the driver off. A read of a level register returns the stored bit for pins in output mode and the synchronized pad level for all other pins. Software may store a level before it switches a pin to output, so the pin starts at a known value.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Bank b (b = 0..3) covers pins 0-1, 2-5, 6-9 and 10-15 respectively. Its level register is at byte address 0x170 + 4*b and its mode register at 0x180 + 4*b. The drive-type register is at 0x190. Bit k of a bank's level register belongs to the bank's k-th pin, counted from the bank's lowest pin. Bit n of the drive-type register belongs to pin n.
- R2: After reset, every mode nibble reads 0x1, every stored level bit is 0, every drive-type bit is 0, and no pad output enable is asserted.
- R3: A pin's mode occupies bits [4k+3:4k] of its bank's mode register, where k is the pin's index within the bank. Only the code 0x8 may assert the pin's output enable. Any other code (including 0x1, 0x2 and 0xF) keeps the enable low.
- R4: A pin in mode 0x8 whose drive-type bit is 0 has its output enable high, and its pad output equals its stored level bit.
- R5: A pin in mode 0x8 whose drive-type bit is 1 asserts its output enable only while its stored level is 0. In that case it drives the pad low. The pad output is never 1 while the pin's enable is high.
- R6: A level register read returns the stored bit for each pin in mode 0x8. For each other pin it returns the pad input as sampled two clock edges earlier. A pad change is therefore visible after the second rising edge, and not after the first.
- R7: A read of any address other than the nine registers returns zero. A write to any such address changes nothing. Write data bits above a bank's width (above 4 times the pin count for a mode register, above 16 for the drive-type register) are discarded and read back as zero.
- R8: A register write takes effect at the rising edge on which the write enable is sampled. Reads and idle cycles leave all register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pad_in | input | 16 | Level present on each pin |
| pad_out | output | 16 | Level driven on each pin when enabled |
| pad_oe | output | 16 | Output enable per pin |

## Verification
Two things can happen on the same edge: a mode write switches a pin from input to output, and the pad input of a neighbouring pin in the same bank changes level. The bench provokes this by issuing the mode write and the pad change in the same cycle. It then reads the bank's level register on the following two cycles. The switched pin must already show its stored bit. The neighbour must show its old level after one edge and its new level only after two. A per-pin behavioural reference model, compared on every clock, judges both this overlap and all other traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NUM_PINS    = 16;
    localparam int NUM_BANKS   = 4;
    localparam int MODE_W      = 4;
    localparam int BANK_PINS [NUM_BANKS] = '{2, 4, 4, 6};

    localparam int LEVEL_BASE  = 'h170;
    localparam int MODE_BASE   = 'h180;
    localparam int DRIVE_ADDR  = 'h190;
    localparam int BANK_STRIDE = 4;

    localparam logic [MODE_W-1:0] MODE_IN  = 4'h1;
    localparam logic [MODE_W-1:0] MODE_OUT = 4'h8;

    // Pad-side control of one pin.
    typedef struct packed {
        logic enable;
        logic level;
    } pad_ctl_t;

    function automatic int bank_first(input int b);
        int acc;
        acc = 0;
        for (int i = 0; i < b; i++) acc += BANK_PINS[i];
        return acc;
    endfunction

    // Driver decision for one pin from mode, stored level and drive type.
    function automatic pad_ctl_t pin_ctl(input logic [MODE_W-1:0] mode,
                                         input logic stored,
                                         input logic open_drain);
        pad_ctl_t c;
        c.enable = (mode == MODE_OUT) && (!open_drain || !stored);
        c.level  = stored && !open_drain;
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int                PINS      = 2,
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] LVL_ADDR  = '0,
    parameter logic [ADDR_W-1:0] MODE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PINS-1:0]   pin_sync,
    input  logic [PINS-1:0]   open_drain,
    output logic [DATA_W-1:0] rd_data,
    output logic [PINS-1:0]   pad_lvl,
    output logic [PINS-1:0]   pad_en,
    output logic [PINS-1:0]   pin_is_out
);
    localparam int MODE_BITS = PINS * MODE_W;

    logic [PINS-1:0]      level_q;
    logic [MODE_BITS-1:0] mode_q;
    logic [PINS-1:0]      rd_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            mode_q  <= {PINS{MODE_IN}};
        end else if (bus_we) begin
            if (bus_addr == LVL_ADDR)  level_q <= bus_wdata[PINS-1:0];
            if (bus_addr == MODE_ADDR) mode_q  <= bus_wdata[MODE_BITS-1:0];
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pad_ctl_t ctl;
        logic [MODE_W-1:0] mode_i;
        assign mode_i        = mode_q[i*MODE_W +: MODE_W];
        assign ctl           = pin_ctl(mode_i, level_q[i], open_drain[i]);
        assign pad_lvl[i]    = ctl.level;
        assign pad_en[i]     = ctl.enable;
        assign pin_is_out[i] = (mode_i == MODE_OUT);
        assign rd_bits[i]    = pin_is_out[i] ? level_q[i] : pin_sync[i];
    end

    always_comb begin
        rd_data = '0;
        if (bus_addr == LVL_ADDR)
            rd_data = {{(DATA_W-PINS){1'b0}}, rd_bits};
        else if (bus_addr == MODE_ADDR)
            rd_data = {{(DATA_W-MODE_BITS){1'b0}}, mode_q};
    end
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [15:0]       pad_in,
    output logic [15:0]       pad_out,
    output logic [15:0]       pad_oe
);
    localparam logic [ADDR_W-1:0] DRV_ADDR = ADDR_W'(DRIVE_ADDR);

    logic [NUM_PINS-1:0] drive_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_is_out;
    logic [DATA_W-1:0]   bank_rd [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst)
            drive_q <= '0;
        else if (bus_we && bus_addr == DRV_ADDR)
            drive_q <= bus_wdata[NUM_PINS-1:0];
    end

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int FIRST = bank_first(b);
        localparam int PINS  = BANK_PINS[b];
        gpio_bank_regs #(
            .PINS      (PINS),
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .LVL_ADDR  (ADDR_W'(LEVEL_BASE + BANK_STRIDE * b)),
            .MODE_ADDR (ADDR_W'(MODE_BASE + BANK_STRIDE * b))
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .bus_addr   (bus_addr),
            .bus_we     (bus_we),
            .bus_wdata  (bus_wdata),
            .pin_sync   (pin_sync[FIRST +: PINS]),
            .open_drain (drive_q[FIRST +: PINS]),
            .rd_data    (bank_rd[b]),
            .pad_lvl    (pad_out[FIRST +: PINS]),
            .pad_en     (pad_oe[FIRST +: PINS]),
            .pin_is_out (pin_is_out[FIRST +: PINS])
        );
    end

    always_comb begin
        bus_rdata = (bus_addr == DRV_ADDR) ? {{(DATA_W-NUM_PINS){1'b0}}, drive_q} : '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata |= bank_rd[b];
    end
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [15:0]       pad_out,
    input logic [15:0]       pad_oe,
    input logic [15:0]       drive_q,
    input logic [15:0]       pin_is_out
);
    logic mapped;
    always_comb begin
        mapped = (bus_addr == ADDR_W'(DRIVE_ADDR));
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(LEVEL_BASE + BANK_STRIDE * b)) mapped = 1'b1;
            if (bus_addr == ADDR_W'(MODE_BASE + BANK_STRIDE * b))  mapped = 1'b1;
        end
    end

    p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pad_oe == '0);

    p_oe_only_output_mode_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~pin_is_out) == '0);

    p_pushpull_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        ((pin_is_out & ~drive_q) ^ (pad_oe & ~drive_q)) == '0);

    p_od_never_high_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & drive_q & pad_out) == '0);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == '0);

    p_drive_write_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(DRIVE_ADDR)) |=> drive_q == $past(bus_wdata[15:0]));

    p_drive_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(bus_we) && !$past(rst)) |-> $stable(drive_q));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .drive_q    (drive_q),
    .pin_is_out (pin_is_out)
);

// File: tb/gpio_banked_ctrl_bench.sv
module gpio_banked_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;

    gpio_banked_ctrl u_gpio_banked_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference model, one entry per pin.
    logic [15:0] m_lvl, m_od, m_s1, m_s2;
    logic [3:0]  m_mode [16];

    function automatic int bank_of(input int p);
        if (p < 2)  return 0;
        if (p < 6)  return 1;
        if (p < 10) return 2;
        return 3;
    endfunction

    function automatic int first_of(input int b);
        case (b)
            0: return 0;
            1: return 2;
            2: return 6;
            default: return 10;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lvl = '0; m_od = '0; m_s1 = '0; m_s2 = '0;
            for (int p = 0; p < 16; p++) m_mode[p] = 4'h1;
        end else begin
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_we) begin
                for (int p = 0; p < 16; p++) begin
                    int b, l;
                    b = bank_of(p);
                    l = p - first_of(b);
                    if (int'(bus_addr) == 'h170 + 4*b) m_lvl[p] = bus_wdata[l];
                    if (int'(bus_addr) == 'h180 + 4*b) m_mode[p] = bus_wdata[4*l +: 4];
                end
                if (bus_addr == 12'h190) m_od = bus_wdata[15:0];
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] r;
        r = '0;
        for (int p = 0; p < 16; p++) begin
            int b, l;
            b = bank_of(p);
            l = p - first_of(b);
            if (int'(a) == 'h170 + 4*b) r[l] = (m_mode[p] == 4'h8) ? m_lvl[p] : m_s2[p];
            if (int'(a) == 'h180 + 4*b) r[4*l +: 4] = m_mode[p];
        end
        if (a == 12'h190) r[15:0] = m_od;
        return r;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] r;
        for (int p = 0; p < 16; p++)
            r[p] = (m_mode[p] == 4'h8) && (!m_od[p] || !m_lvl[p]);
        return r;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] r;
        for (int p = 0; p < 16; p++)
            r[p] = (m_mode[p] == 4'h8) && !m_od[p] && m_lvl[p];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, mid-low-phase.
    always begin
        @(negedge clk);
        #2;
        if (cmp_en) begin
            chk("R3 R4 R5 pad_oe model", {16'h0, pad_oe}, {16'h0, exp_oe()});
            chk("R4 R5 pad_out model (enabled pins)", {16'h0, pad_out & pad_oe},
                {16'h0, exp_out() & exp_oe()});
            chk("R1 R6 R7 rdata model", bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #3;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R2 reset state
        rd(12'h18C, 32'h0011_1111, "R2 bank3 mode after reset");
        rd(12'h180, 32'h0000_0011, "R2 bank0 mode after reset");
        rd(12'h190, 32'h0, "R2 drive type after reset");
        chk("R2 no output enable after reset", {16'h0, pad_oe}, 32'h0);

        // R6 R1 input reads through synchronizer
        @(negedge clk); pad_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        rd(12'h178, 32'h7, "R1 R6 bank2 input read");
        rd(12'h174, 32'h0, "R1 R6 bank1 input read");

        // R6 two-edge latency
        @(negedge clk);
        pad_in = 16'hA5C2; bus_addr = 12'h170;
        #3 chk("R6 no edge yet", bus_rdata, 32'h3);
        @(negedge clk); #3 chk("R6 one edge: old level", bus_rdata, 32'h3);
        @(negedge clk); #3 chk("R6 two edges: new level", bus_rdata, 32'h2);

        // R4 R7 push-pull outputs on bank3, excess bits dropped
        wr(12'h17C, 32'hFFFF_FFC5);
        wr(12'h18C, 32'hFF88_8888);
        rd(12'h18C, 32'h0088_8888, "R7 R3 mode upper bits dropped");
        rd(12'h17C, 32'h0000_0005, "R6 R7 output read returns stored bits");
        chk("R4 push-pull enables", {26'h0, pad_oe[15:10]}, 32'h3F);
        chk("R4 push-pull levels", {26'h0, pad_out[15:10]}, 32'h05);

        // R5 open drain on pins 10, 13, 15
        wr(12'h190, 32'hFFFF_A400);
        rd(12'h190, 32'h0000_A400, "R1 R7 drive type readback");
        chk("R5 open-drain enables", {26'h0, pad_oe[15:10]}, 32'h3E);
        chk("R5 levels of enabled pins", {26'h0, pad_out[15:10] & pad_oe[15:10]}, 32'h04);

        // R3 non-output codes on bank1
        wr(12'h174, 32'hF);
        wr(12'h184, 32'h8F28);
        chk("R3 only code 8 enables", {28'h0, pad_oe[5:2]}, 32'h9);
        rd(12'h174, 32'h9, "R3 R6 mixed-mode bank1 read");

        // R7 unmapped accesses
        rd(12'h194, 32'h0, "R7 unmapped 0x194 reads zero");
        rd(12'h16C, 32'h0, "R7 unmapped 0x16C reads zero");
        rd(12'h172, 32'h0, "R7 misaligned 0x172 reads zero");
        wr(12'h191, 32'h0000_FFFF);
        wr(12'h185, 32'h0000_0000);
        rd(12'h190, 32'h0000_A400, "R7 write to 0x191 ignored");
        rd(12'h184, 32'h0000_8F28, "R7 write to 0x185 ignored");
        chk("R7 pads unchanged after unmapped writes", {16'h0, pad_oe}, 32'hF824);

        // R8 concurrent mode switch and neighbour pad change
        wr(12'h170, 32'h1);
        @(negedge clk);
        bus_addr = 12'h180; bus_we = 1'b1; bus_wdata = 32'h18;
        pad_in[1] = 1'b0;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h170;
        #3;
        chk("R8 R6 switch visible next edge, neighbour old", bus_rdata, 32'h3);
        chk("R8 R4 pin0 driven high", {30'h0, pad_oe[0], pad_out[0]}, 32'h3);
        @(negedge clk); #3;
        chk("R6 neighbour new level after second edge", bus_rdata, 32'h1);

        // R8 repeated reads change nothing
        rd(12'h190, 32'h0000_A400, "R8 read has no side effect a");
        rd(12'h190, 32'h0000_A400, "R8 read has no side effect b");

        // R2 reset again mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(12'h18C, 32'h0011_1111, "R2 mode after second reset");
        chk("R2 outputs off after second reset", {16'h0, pad_oe}, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule